// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a DRAM's contents alive by issuing CAS-before-RAS refresh cycles on a fixed average cadence. The DRAM holds its own refresh row pointer, so the scheduler never drives an address. It only sequences the strobes: column strobe low first, then row strobe low, with the write enable held inactive (high) the whole time. An interval timer adds one owed refresh to a pending count every refresh slot. With the default 50 MHz clock, one slot is 15.6 us (780 cycles), or 31.2 us (1560 cycles) when the low-power parameter is set. Either way, 4096 refreshes fit within the retention period.

The scheduler shares the DRAM bus with an access sequencer through a hold/acknowledge handshake. It asks for the bus when refreshes are owed and the sequencer reports an idle point. It also asks, whatever the idle input says, once eight refreshes are owed. It drives the strobes only after the bus has been granted, and it releases the bus after row precharge. If a slot expires while the pending count is already full, the owed refresh is lost and a sticky error flag rises.

Top module: `cbr_refresh_sched`

## Requirements
- R1: A refresh becomes owed once every refresh slot: 780 clock cycles at 50 MHz with LOW_POWER=0, and 1560 cycles with LOW_POWER=1. The first slot ends 780 (or 1560) cycles after reset.
- R2: While at least one refresh is owed, the bus is not held and idle_i is high, hold_o rises on the next clock edge.
- R3: When eight refreshes are owed, hold_o rises even though idle_i is low.
- R4: Once raised, hold_o stays high until the refresh cycle has finished precharge. ras_n_o and cas_n_o stay high until ack_i has been seen high.
- R5: cas_n_o falls one clock (the 5 ns setup rounded up) before ras_n_o falls.
- R6: cas_n_o stays low for one clock after ras_n_o falls, then returns high while ras_n_o is still low.
- R7: ras_n_o stays low for three clocks (60 ns), then stays high for at least two clocks (40 ns precharge) before hold_o falls.
- R8: we_n_o is high at all times.
- R9: Each completed refresh cycle retires exactly one owed refresh, so a backlog of N is cleared by exactly N cycles.
- R10: A slot that ends while eight refreshes are already owed sets err_o. The count stays at eight, and err_o stays high until reset.
- R11: After reset, hold_o and err_o are low, ras_n_o, cas_n_o and we_n_o are high, and no refresh is owed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | Access sequencer is at an idle point |
| ack_i | input | 1 | Access sequencer has handed over the bus |
| hold_o | output | 1 | Request for, and ownership of, the DRAM bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| err_o | output | 1 | Sticky flag: an owed refresh was lost |

## Verification
A wrong pending count appears at the ports within one refresh slot. A count that is too high raises hold without idle too early. A count that is too low delays the forced hold past the eighth slot, or leaves hold asserted after a drained backlog has too many or too few row strobes. A wrong sequencer state shows up on the strobes within one or two clocks: the column/row order, the strobe widths and the hold release are compared clock by clock against the expected pattern. A saturation fault shows up on the error flag one clock after the ninth slot.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_REQ   = 3'd1,
    SQ_CSR   = 3'd2,
    SQ_RASLO = 3'd3,
    SQ_PRE   = 3'd4
  } seq_st_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_mhz);
    int unsigned c;
    c = (ns * clk_mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Refresh slot length in tenths of a microsecond.
  function automatic int unsigned slot_tenths_us(input bit low_power);
    return low_power ? 312 : 156;
  endfunction

  // Refresh slot length in clock cycles, rounded up.
  function automatic int unsigned slot_cycles(input bit low_power,
                                              input int unsigned clk_mhz);
    return (slot_tenths_us(low_power) * clk_mhz + 9) / 10;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cbr_pend_counter.sv
module cbr_pend_counter #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          done_i,
  output logic [PW-1:0] pend_o,
  output logic          full_o,
  output logic          err_o
);
  localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

  logic [PW-1:0] pend_q;
  logic          err_q;

  assign pend_o = pend_q;
  assign full_o = (pend_q == FULL);
  assign err_o  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case ({tick_i, done_i})
        2'b10: begin
          if (full_o) err_q  <= 1'b1;
          else        pend_q <= pend_q + 1'b1;
        end
        2'b01: begin
          if (pend_q != '0) pend_q <= pend_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_pkg::*;
#(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned CHR_CYC = 1,
  parameter int unsigned RAS_CYC = 3,
  parameter int unsigned RP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed_i,
  input  logic urgent_i,
  input  logic idle_i,
  input  logic ack_i,
  output logic hold_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o
);
  localparam int unsigned LONGEST = max2(max2(CSR_CYC, RAS_CYC), RP_CYC);
  localparam int unsigned CW = $clog2(LONGEST + 1);

  seq_st_t       st_q, st_nx;
  logic [CW-1:0] cnt_q;
  logic          last;

  always_comb begin
    unique case (st_q)
      SQ_CSR:   last = (cnt_q == CW'(CSR_CYC - 1));
      SQ_RASLO: last = (cnt_q == CW'(RAS_CYC - 1));
      SQ_PRE:   last = (cnt_q == CW'(RP_CYC - 1));
      default:  last = 1'b0;
    endcase
  end

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      SQ_IDLE:  if (owed_i && (idle_i || urgent_i)) st_nx = SQ_REQ;
      SQ_REQ:   if (ack_i) st_nx = SQ_CSR;
      SQ_CSR:   if (last)  st_nx = SQ_RASLO;
      SQ_RASLO: if (last)  st_nx = SQ_PRE;
      SQ_PRE:   if (last)  st_nx = SQ_IDLE;
      default:  st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= (st_nx != st_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign hold_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_PRE) && last;
  assign ras_n_o = (st_q != SQ_RASLO);
  assign cas_n_o = !((st_q == SQ_CSR) ||
                     ((st_q == SQ_RASLO) && (cnt_q < CW'(CHR_CYC))));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 50,
  parameter bit          LOW_POWER = 1'b0,
  parameter int unsigned MAX_PEND  = 8,
  parameter int unsigned T_CSR_NS  = 5,
  parameter int unsigned T_CHR_NS  = 10,
  parameter int unsigned T_RAS_NS  = 60,
  parameter int unsigned T_RP_NS   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic ack_i,
  output logic hold_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic err_o
);
  localparam int unsigned INTERVAL = slot_cycles(LOW_POWER, CLK_MHZ);
  localparam int unsigned CSR_CYC  = ns_to_cycles(T_CSR_NS, CLK_MHZ);
  localparam int unsigned CHR_CYC  = ns_to_cycles(T_CHR_NS, CLK_MHZ);
  localparam int unsigned RAS_CYC  = ns_to_cycles(T_RAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC   = ns_to_cycles(T_RP_NS, CLK_MHZ);
  localparam int unsigned PW       = $clog2(MAX_PEND + 1);

  // Internal events, named for the checker.
  logic          tick;
  logic          done;
  logic          full;
  logic [PW-1:0] pend;

  cbr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  cbr_pend_counter #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .done_i (done),
    .pend_o (pend),
    .full_o (full),
    .err_o  (err_o)
  );

  cbr_strobe_seq #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .owed_i   (pend != '0),
    .urgent_i (full),
    .idle_i   (idle_i),
    .ack_i    (ack_i),
    .hold_o   (hold_o),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .done_o   (done)
  );

  // A CBR cycle never writes: write enable stays inactive.
  assign we_n_o = 1'b1;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_i,
  input logic          hold_o,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          err_o,
  input logic          tick,
  input logic          done,
  input logic [PW-1:0] pend
);
  // R5: column strobe already low on the cycle before the row strobe falls
  p_cas_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  // R4: the column strobe only starts after the bus was granted
  p_grant_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> $past(ack_i));

  // R4: row strobe low only while the bus is held
  p_ras_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> hold_o);

  // R6: column strobe released while the row strobe is still low
  p_cas_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n_o) |-> !ras_n_o);

  // R7: precharge lasts more than one cycle
  p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |=> ras_n_o);

  // R3: a full backlog forces a bus request
  p_forced_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PW'(MAX_PEND) && !done) |=> hold_o);

  // R10: overflow raises the flag, and the flag never clears
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PW'(MAX_PEND) && tick && !done) |=> err_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  p_pend_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));

  // R9: one retire per completed cycle
  p_retire_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick) |=> (pend == $past(pend) - 1'b1));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.MAX_PEND(MAX_PEND)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack_i   (ack_i),
  .hold_o  (hold_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .err_o   (err_o),
  .tick    (tick),
  .done    (done),
  .pend    (pend)
);

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
  localparam int PERIOD_NS = 20;
  localparam int SLOT      = 15600 / PERIOD_NS;  // 780
  localparam int SLOT_LP   = 31200 / PERIOD_NS;  // 1560
  localparam int DEPTH     = 8;

  // {hold, ras_n, cas_n, we_n} per cycle after the grant
  localparam logic [3:0] SEQ_VEC [7] = '{
    4'b1101, 4'b1001, 4'b1011, 4'b1011, 4'b1111, 4'b1111, 4'b0111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_lp_n = 1'b0;
  logic idle_i = 1'b0, ack_i = 1'b0;
  logic hold_o, ras_n_o, cas_n_o, we_n_o, err_o;
  logic hold_lp, ras_lp, cas_lp, we_lp, err_lp;

  int compared = 0;
  int mismatched = 0;
  int cyc_lp = 0;
  int first_lp = -1;

  always #(PERIOD_NS / 2) clk = ~clk;

  cbr_refresh_sched u_cbr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .ack_i(ack_i),
    .hold_o(hold_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .err_o(err_o)
  );

  cbr_refresh_sched #(.LOW_POWER(1'b1)) u_cbr_refresh_sched_lp (
    .clk(clk), .rst_n(rst_lp_n), .idle_i(1'b0), .ack_i(1'b0),
    .hold_o(hold_lp), .ras_n_o(ras_lp), .cas_n_o(cas_lp),
    .we_n_o(we_lp), .err_o(err_lp)
  );

  always @(negedge clk) begin
    if (rst_lp_n) begin
      cyc_lp <= cyc_lp + 1;
      if (hold_lp && first_lp < 0) first_lp <= cyc_lp + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * PERIOD_NS);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int falls;
    logic prev;
    logic early_low;
    cycles(3);
    rst_lp_n = 1'b1;

    // R11: reset state
    do_reset();
    check("R11 hold", hold_o, 0);
    check("R11 ras_n", ras_n_o, 1);
    check("R11 cas_n", cas_n_o, 1);
    check("R11 we_n", we_n_o, 1);
    check("R11 err", err_o, 0);

    // R1 / R2: idle and granted from reset, one refresh per slot
    idle_i = 1'b1; ack_i = 1'b1;
    falls = 0; prev = 1'b1; early_low = 1'b0;
    for (int i = 1; i <= 2 * SLOT + 40; i++) begin
      @(negedge clk);
      if (i < SLOT - 2 && (!ras_n_o || hold_o)) early_low = 1'b1;
      if (prev && !ras_n_o) falls++;
      prev = ras_n_o;
    end
    check("R1 no refresh before first slot", early_low, 0);
    check("R1 refreshes in two slots", falls, 2);

    // R3 / R10: backlog with no idle and no grant
    idle_i = 1'b0; ack_i = 1'b0;
    do_reset();
    cycles(DEPTH * SLOT - 10);
    check("R3 no hold below full backlog", hold_o, 0);
    cycles(20);
    check("R3 forced hold at full backlog", hold_o, 1);
    check("R4 strobes idle while waiting", {ras_n_o, cas_n_o}, 3);
    cycles(SLOT - 40);
    check("R10 no error before overflow", err_o, 0);
    cycles(40);
    check("R10 error after lost slot", err_o, 1);

    // R4 R5 R6 R7 R8: strobe pattern after the grant
    ack_i = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check($sformatf("R5 R6 R7 R8 sequence row %0d", i),
            {hold_o, ras_n_o, cas_n_o, we_n_o}, SEQ_VEC[i]);
    end

    // R2 / R9: seven still owed (8 kept, one retired); drain at idle
    idle_i = 1'b1;
    @(negedge clk);
    check("R2 hold one cycle after idle", hold_o, 1);
    falls = 0; prev = ras_n_o;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (prev && !ras_n_o) falls++;
      prev = ras_n_o;
    end
    check("R9 backlog drained count", falls, 7);
    check("R9 hold released after drain", hold_o, 0);
    check("R10 error sticky", err_o, 1);
    check("R8 we_n high", we_n_o, 1);

    idle_i = 1'b0;
    do_reset();
    check("R11 error cleared by reset", err_o, 0);

    // R1: low-power slot length, forced hold after eight slots
    while (cyc_lp < DEPTH * SLOT_LP + 20) @(negedge clk);
    compared++;
    if (first_lp < DEPTH * SLOT_LP - 2 || first_lp > DEPTH * SLOT_LP + 6) begin
      mismatched++;
      $display("FAIL R1 low-power hold cycle: actual %0d expected %0d",
               first_lp, DEPTH * SLOT_LP + 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule